// File: doc/BRIEF.md
# Serial Port Status Register with Read-Then-Clear Protection

This block is the 8-bit status register of a UART-style serial port. It gathers transmit and receive status flags raised by the serial datapath, holds a received multiprocessor bit and a multiprocessor bit to be sent, and raises the transmit-end interrupt request. A synchronous CPU port reads and writes the register. The serial shifter, the baud generator and the receive path sit outside the block and reach it only through single-cycle event pulses and two control levels.

Software clears a status flag by writing 0 to it, but only after it has read that flag as 1. Each clearable flag therefore has a hidden arm bit. A CPU read that sees the flag at 1 sets the arm bit. A qualifying clear resets it, and so does a new hardware set of the same flag. Writing 1 never sets a flag. The transmit-end flag and the received multiprocessor bit are read-only.

Field names used below are, from bit 7 down to bit 0: TXEMPTY (transmit buffer empty), RXFULL (receive data ready), OVRUN (overrun), FRMERR (framing error), PARERR (parity error), TXDONE (transmit end), MPRX (received multiprocessor bit) and MPTX (multiprocessor bit to transmit).

Top module: `sio_stat_reg`

## Requirements
- R1: The register layout from bit 7 to bit 0 is TXEMPTY, RXFULL, OVRUN, FRMERR, PARERR, TXDONE, MPRX, MPTX. RXFULL is set by `hw_rx_done`, OVRUN by `hw_overrun`, FRMERR by `hw_frame_err` and PARERR by `hw_parity_err`. Each of these is a single-cycle pulse that takes effect at the next clock edge.
- R2: During reset and right after it, the register reads 0x84: TXEMPTY=1, TXDONE=1 and every other bit 0.
- R3: Writing 1 to TXEMPTY, RXFULL, OVRUN, FRMERR or PARERR never changes that bit.
- R4: Writing 0 to one of those five flags clears it only if a CPU read has returned that flag as 1 since the flag was last set. Otherwise the flag keeps its value.
- R5: TXDONE (bit 2) and MPRX (bit 1) ignore CPU writes. A `hw_mpb_load` pulse loads MPRX from `hw_mpb_val`.
- R6: MPTX (bit 0) takes `cpu_wdata[0]` on every CPU write and is read back unchanged.
- R7: A `hw_tdr_load` pulse sets TXEMPTY. While `tx_en` is 0, TXEMPTY is forced to 1.
- R8: A `hw_tx_end` pulse sets TXDONE. TXDONE clears only in the cycle in which a qualifying software clear of TXEMPTY takes place.
- R9: `tei_req` is 1 exactly while `tei_en` is 1 and TXDONE is 1.
- R10: If a hardware set and a qualifying software clear hit the same flag in the same cycle, the flag stays 1. The set also disarms the flag, so a fresh read is needed before a clear can succeed.
- R11: `cpu_rdata` shows the register value from before any update in the current cycle while `cpu_cs` and `cpu_re` are both 1, and reads 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_cs | input | 1 | CPU chip select |
| cpu_we | input | 1 | CPU write enable |
| cpu_re | input | 1 | CPU read strobe |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| tx_en | input | 1 | Transmitter enable control level |
| tei_en | input | 1 | Transmit-end interrupt enable |
| hw_tdr_load | input | 1 | Pulse: transmit data moved to the shift register |
| hw_rx_done | input | 1 | Pulse: a frame was received |
| hw_overrun | input | 1 | Pulse: overrun detected |
| hw_frame_err | input | 1 | Pulse: framing error detected |
| hw_parity_err | input | 1 | Pulse: parity error detected |
| hw_tx_end | input | 1 | Pulse: transmission ended with no new data |
| hw_mpb_load | input | 1 | Pulse: load the received multiprocessor bit |
| hw_mpb_val | input | 1 | Value of the received multiprocessor bit |
| tei_req | output | 1 | Transmit-end interrupt request |

## Verification
The properties assume that every hardware event input is a clean synchronous level, sampled at the rising edge and known from reset release onward. They also assume that the CPU strobes count only when qualified by `cpu_cs`. The stimulus changes every input at the falling edge and holds each event pulse for exactly one cycle. It drives the CPU strobes only together with chip select, so reads, writes and events never straddle an edge. Set-versus-clear collisions are produced on purpose by driving an event pulse in the same cycle as a write.

// File: rtl/sio_stat_pkg.sv
package sio_stat_pkg;

    localparam int REG_W = 8;

    // Bit positions; software decodes these, so they are fixed.
    localparam int B_TXEMPTY = 7;
    localparam int B_RXFULL  = 6;
    localparam int B_OVRUN   = 5;
    localparam int B_FRMERR  = 4;
    localparam int B_PARERR  = 3;
    localparam int B_TXDONE  = 2;
    localparam int B_MPRX    = 1;
    localparam int B_MPTX    = 0;

    // The protected flags occupy a contiguous run from PARERR upward.
    localparam int N_PROT   = B_TXEMPTY - B_PARERR + 1;
    localparam int IDX_TXE  = B_TXEMPTY - B_PARERR;

    localparam logic [REG_W-1:0] RST_VAL = 8'h84;

    typedef struct packed {
        logic flag;
        logic arm;
    } prot_state_t;

    typedef struct packed {
        logic done;
    } txdone_state_t;

    typedef struct packed {
        logic mprx;
        logic mptx;
    } mp_state_t;

endpackage

// File: rtl/sio_prot_flag.sv
module sio_prot_flag
    import sio_stat_pkg::*;
#(
    parameter logic RST_FLAG = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic clr_o
);

    prot_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        clr_o = wr_i && !wbit_i && st_q.arm && st_q.flag;
        if (set_i) begin
            st_d.flag = 1'b1;
            st_d.arm  = 1'b0;
        end else if (clr_o) begin
            st_d.flag = 1'b0;
            st_d.arm  = 1'b0;
        end else if (rd_i && st_q.flag) begin
            st_d.arm  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flag <= RST_FLAG;
            st_q.arm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/sio_txdone.sv
module sio_txdone
    import sio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic done_o,
    output logic irq_o
);

    txdone_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.done = 1'b1;
        end else if (clr_i) begin
            st_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.done <= RST_VAL[B_TXDONE];
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o = st_q.done;
    assign irq_o  = ie_i && st_q.done;

endmodule

// File: rtl/sio_mp_bits.sv
module sio_mp_bits
    import sio_stat_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic val_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic mprx_o,
    output logic mptx_o
);

    mp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.mprx = val_i;
        end
        if (wr_i) begin
            st_d.mptx = wbit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mprx <= RST_VAL[B_MPRX];
            st_q.mptx <= RST_VAL[B_MPTX];
        end else begin
            st_q <= st_d;
        end
    end

    assign mprx_o = st_q.mprx;
    assign mptx_o = st_q.mptx;

endmodule

// File: rtl/sio_stat_reg.sv
module sio_stat_reg
    import sio_stat_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_cs,
    input  logic             cpu_we,
    input  logic             cpu_re,
    input  logic [REG_W-1:0] cpu_wdata,
    output logic [REG_W-1:0] cpu_rdata,
    input  logic             tx_en,
    input  logic             tei_en,
    input  logic             hw_tdr_load,
    input  logic             hw_rx_done,
    input  logic             hw_overrun,
    input  logic             hw_frame_err,
    input  logic             hw_parity_err,
    input  logic             hw_tx_end,
    input  logic             hw_mpb_load,
    input  logic             hw_mpb_val,
    output logic             tei_req
);

    logic              rd_hit;
    logic              wr_hit;
    logic [N_PROT-1:0] set_vec;
    logic [N_PROT-1:0] flag_vec;
    logic [N_PROT-1:0] clr_vec;
    logic              txdone;
    logic              mprx;
    logic              mptx;
    logic [REG_W-1:0]  stat_w;

    assign rd_hit = cpu_cs && cpu_re;
    assign wr_hit = cpu_cs && cpu_we;

    // Index 0 is PARERR, index N_PROT-1 is TXEMPTY.
    assign set_vec = {hw_tdr_load || !tx_en,
                      hw_rx_done,
                      hw_overrun,
                      hw_frame_err,
                      hw_parity_err};

    for (genvar i = 0; i < N_PROT; i++) begin : g_prot
        sio_prot_flag #(
            .RST_FLAG (RST_VAL[B_PARERR + i])
        ) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_vec[i]),
            .rd_i   (rd_hit),
            .wr_i   (wr_hit),
            .wbit_i (cpu_wdata[B_PARERR + i]),
            .flag_o (flag_vec[i]),
            .clr_o  (clr_vec[i])
        );
    end

    sio_txdone u_txdone (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hw_tx_end),
        .clr_i  (clr_vec[IDX_TXE]),
        .ie_i   (tei_en),
        .done_o (txdone),
        .irq_o  (tei_req)
    );

    sio_mp_bits u_mp (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (hw_mpb_load),
        .val_i  (hw_mpb_val),
        .wr_i   (wr_hit),
        .wbit_i (cpu_wdata[B_MPTX]),
        .mprx_o (mprx),
        .mptx_o (mptx)
    );

    assign stat_w    = {flag_vec, txdone, mprx, mptx};
    assign cpu_rdata = rd_hit ? stat_w : '0;

endmodule

// File: rtl/sio_stat_chk.sv
module sio_stat_chk
    import sio_stat_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_cs,
    input logic             cpu_we,
    input logic [REG_W-1:0] cpu_wdata,
    input logic             tx_en,
    input logic             hw_rx_done,
    input logic             hw_tx_end,
    input logic             hw_mpb_load,
    input logic [REG_W-1:0] stat_w
);

    a_r2_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (stat_w == RST_VAL));

    a_r3_rxfull_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_w[B_RXFULL] && !hw_rx_done) |=> !stat_w[B_RXFULL]);

    a_r5_txdone_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_w[B_TXDONE] && !hw_tx_end) |=> !stat_w[B_TXDONE]);

    a_r5_mprx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_mpb_load |=> $stable(stat_w[B_MPRX]));

    a_r6_mptx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_cs && cpu_we) |=> (stat_w[B_MPTX] == $past(cpu_wdata[B_MPTX])));

    a_r7_txempty_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> stat_w[B_TXEMPTY]);

    a_r8_txdone_falls_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_w[B_TXDONE]) |-> $past(cpu_cs && cpu_we && !cpu_wdata[B_TXEMPTY]));

endmodule

bind sio_stat_reg sio_stat_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_cs      (cpu_cs),
    .cpu_we      (cpu_we),
    .cpu_wdata   (cpu_wdata),
    .tx_en       (tx_en),
    .hw_rx_done  (hw_rx_done),
    .hw_tx_end   (hw_tx_end),
    .hw_mpb_load (hw_mpb_load),
    .stat_w      (stat_w)
);

// File: tb/tb_sio_stat_reg.sv
`timescale 1ns/1ps
module tb_sio_stat_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_cs = 1'b0, cpu_we = 1'b0, cpu_re = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       tx_en = 1'b1, tei_en = 1'b1;
    logic       hw_tdr_load = 1'b0, hw_rx_done = 1'b0, hw_overrun = 1'b0;
    logic       hw_frame_err = 1'b0, hw_parity_err = 1'b0, hw_tx_end = 1'b0;
    logic       hw_mpb_load = 1'b0, hw_mpb_val = 1'b0;
    logic       tei_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sio_stat_reg dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_cs(cpu_cs), .cpu_we(cpu_we), .cpu_re(cpu_re),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .tx_en(tx_en), .tei_en(tei_en),
        .hw_tdr_load(hw_tdr_load), .hw_rx_done(hw_rx_done),
        .hw_overrun(hw_overrun), .hw_frame_err(hw_frame_err),
        .hw_parity_err(hw_parity_err), .hw_tx_end(hw_tx_end),
        .hw_mpb_load(hw_mpb_load), .hw_mpb_val(hw_mpb_val),
        .tei_req(tei_req)
    );

    localparam logic [1:0] IDLE = 2'd0, RD = 2'd1, WR = 2'd2;
    // Event byte: 7 tdr_load, 6 rx_done, 5 overrun, 4 frame, 3 parity,
    // 2 tx_end, 1 mpb_load, 0 mpb_val.  Row: {op, wdata, events, expected read}.
    localparam int NV = 28;
    localparam logic [25:0] TBL [NV] = '{
        {RD,   8'h00, 8'h00, 8'h84},  // R2 reset, arms TXEMPTY
        {WR,   8'h00, 8'h00, 8'h00},  // R4/R8 clear TXEMPTY and TXDONE
        {RD,   8'h00, 8'h00, 8'h00},
        {IDLE, 8'h00, 8'h60, 8'h00},  // R1 rx_done + overrun
        {RD,   8'h00, 8'h00, 8'h60},
        {WR,   8'hFF, 8'h00, 8'h00},  // R3 ones ignored, R6 MPTX=1
        {RD,   8'h00, 8'h00, 8'h61},
        {WR,   8'h41, 8'h00, 8'h00},  // R4 clear OVRUN only
        {RD,   8'h00, 8'h00, 8'h41},
        {IDLE, 8'h00, 8'h18, 8'h00},  // R1 frame + parity
        {WR,   8'h01, 8'h00, 8'h00},  // R4 unread FRMERR/PARERR stay
        {RD,   8'h00, 8'h00, 8'h19},
        {IDLE, 8'h00, 8'h08, 8'h00},  // R10 re-set disarms PARERR
        {WR,   8'h01, 8'h00, 8'h00},
        {RD,   8'h00, 8'h00, 8'h09},
        {WR,   8'h01, 8'h08, 8'h00},  // R10 set wins over clear
        {WR,   8'h01, 8'h00, 8'h00},  // R10 disarmed, no clear
        {RD,   8'h00, 8'h00, 8'h09},
        {RD,   8'h00, 8'h00, 8'h09},
        {WR,   8'h00, 8'h00, 8'h00},  // R4 armed clear, R6 MPTX=0
        {RD,   8'h00, 8'h00, 8'h00},
        {IDLE, 8'h00, 8'h03, 8'h00},  // R5 load MPRX=1
        {WR,   8'h00, 8'h00, 8'h00},  // R5 write ignored
        {RD,   8'h00, 8'h00, 8'h02},
        {IDLE, 8'h00, 8'h84, 8'h00},  // R7/R8 tdr_load + tx_end
        {RD,   8'h00, 8'h00, 8'h86},
        {IDLE, 8'h00, 8'h02, 8'h00},  // R5 load MPRX=0
        {RD,   8'h00, 8'h00, 8'h84}
    };

    task automatic drive(input logic [1:0] op, input logic [7:0] wd, input logic [7:0] ev);
        @(negedge clk);
        cpu_cs        = (op != IDLE);
        cpu_re        = (op == RD);
        cpu_we        = (op == WR);
        cpu_wdata     = wd;
        hw_tdr_load   = ev[7];
        hw_rx_done    = ev[6];
        hw_overrun    = ev[5];
        hw_frame_err  = ev[4];
        hw_parity_err = ev[3];
        hw_tx_end     = ev[2];
        hw_mpb_load   = ev[1];
        hw_mpb_val    = ev[0];
        #1;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 100000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) drive(IDLE, 8'h00, 8'h00);
        // R2: register visible during reset
        drive(RD, 8'h00, 8'h00);
        check("R2 during reset", cpu_rdata, 8'h84);
        drive(IDLE, 8'h00, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i][25:24], TBL[i][23:16], TBL[i][15:8]);
            if (TBL[i][25:24] == RD)
                check($sformatf("R1/R3/R4/R5/R10 row %0d", i), cpu_rdata, TBL[i][7:0]);
        end
        drive(IDLE, 8'h00, 8'h00);

        // R9: request follows enable while TXDONE=1
        check("R9 request on", {7'd0, tei_req}, 8'h01);
        tei_en = 1'b0;
        #1;
        check("R9 request off by enable", {7'd0, tei_req}, 8'h00);
        tei_en = 1'b1;

        // R8/R9: armed clear of TXEMPTY also clears TXDONE, dropping request
        drive(WR, 8'h00, 8'h00);
        drive(RD, 8'h00, 8'h00);
        check("R8 TXEMPTY and TXDONE cleared", cpu_rdata, 8'h00);
        check("R9 request removed", {7'd0, tei_req}, 8'h00);

        // R7: disabling the transmitter forces TXEMPTY
        tx_en = 1'b0;
        drive(IDLE, 8'h00, 8'h00);
        tx_en = 1'b1;
        drive(RD, 8'h00, 8'h00);
        check("R7 TXEMPTY on disable", cpu_rdata, 8'h80);

        // R11: no read strobe gives zero; read shows pre-update value
        cpu_cs = 1'b1; cpu_re = 1'b0;
        #1;
        check("R11 no strobe", cpu_rdata, 8'h00);
        drive(RD, 8'h00, 8'h40);
        check("R11 same-cycle set hidden", cpu_rdata, 8'h80);
        drive(RD, 8'h00, 8'h00);
        check("R11 set visible next read", cpu_rdata, 8'hC0);

        // R2: reset again restores 0x84
        drive(IDLE, 8'h00, 8'h00);
        rst_n = 1'b0;
        drive(IDLE, 8'h00, 8'h00);
        rst_n = 1'b1;
        drive(RD, 8'h00, 8'h00);
        check("R2 after reset", cpu_rdata, 8'h84);

        // R6 and R4: write without prior read; flags stay, MPTX set
        rst_n = 1'b0;
        drive(IDLE, 8'h00, 8'h00);
        rst_n = 1'b1;
        drive(WR, 8'h01, 8'h00);
        drive(RD, 8'h00, 8'h00);
        check("R6 MPTX write, R4 unread TXEMPTY kept", cpu_rdata, 8'h85);

        drive(IDLE, 8'h00, 8'h00);
        finish_run();
    end

endmodule